// File: doc/BRIEF.md
# Byte ALU with Nibble-Carry Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. It is purely combinational. A three-bit operation code selects one of five functions, and the block returns a result together with four condition flags: zero, subtract, half-carry and carry. The surrounding core keeps the register file, decodes the instructions and handles memory. It presents the operands and the current flags to this block, then latches whatever comes back.

The five functions are an 8-bit add, an 8-bit decrement, an 8-bit exclusive-or, an 8-bit bitwise inversion, and a 16-bit stack-pointer adjust. The adjust adds a sign-extended 8-bit offset to a 16-bit pointer. Every carry flag is produced by the same probe. That probe forms the exclusive-or of both addends with their sum, then reads the bit at the position of interest, which yields the carry into that bit. Each operation has its own fixed flag rule: some flags are computed, some are forced to a constant and some are copied from the incoming flags.

There are no states or transitions. Every output depends only on the present inputs.

Top module: `alu8_flags`

## Requirements
- R1: With op_sel = 0 (add), result[7:0] is (opnd_a + opnd_b) mod 256 and the subtract flag (flags_out[2]) is 0.
- R2: With op_sel = 0, half-carry (flags_out[1]) is 1 exactly when the sum of the two low nibbles exceeds 15, and carry (flags_out[0]) is 1 exactly when opnd_a + opnd_b exceeds 255.
- R3: With op_sel = 1 (decrement), result[7:0] is (opnd_a - 1) mod 256, the subtract flag is 1, and carry equals flags_in[0].
- R4: With op_sel = 1, half-carry is 1 exactly when the low nibble of opnd_a is 0.
- R5: With op_sel = 2 (exclusive-or), result[7:0] is opnd_a XOR opnd_b, and subtract, half-carry and carry are all 0.
- R6: With op_sel = 2 and opnd_b equal to opnd_a, the result is 0 and the zero flag (flags_out[3]) is 1.
- R7: With op_sel = 3 (invert), result[7:0] is the bitwise inverse of opnd_a, subtract and half-carry are 1, and zero and carry equal flags_in[3] and flags_in[0].
- R8: With op_sel = 4 (pointer adjust), result is (sp_in + sign-extended opnd_b) mod 65536, and the zero and subtract flags are 0.
- R9: With op_sel = 4, half-carry is 1 when (sp_in[3:0] + opnd_b[3:0]) > 15, and carry is 1 when (sp_in[7:0] + opnd_b) > 255.
- R10: For op_sel 0, 1 and 2, the zero flag is 1 exactly when result[7:0] is 0.
- R11: For op_sel values 5 to 7, result is 0 and flags_out equals flags_in.
- R12: For op_sel 0 to 3, result[15:8] is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code: 0 add, 1 decrement, 2 exclusive-or, 3 invert, 4 pointer adjust |
| opnd_a | input | 8 | First byte operand (accumulator or register being decremented) |
| opnd_b | input | 8 | Second byte operand; signed offset for pointer adjust |
| sp_in | input | 16 | Pointer operand for pointer adjust |
| flags_in | input | 4 | Current flags {zero, subtract, half-carry, carry} |
| result | output | 16 | Operation result; upper byte is zero for byte operations |
| flags_out | output | 4 | Updated flags {zero, subtract, half-carry, carry} |

## Verification
The embedded assertions hold on every input combination for the flag-rule invariants:
- the forced constants,
- the flags copied through for decrement and invert,
- the zero flag tracking the byte result,
- the cleared upper byte,
- the pass-through for unused codes.

Only the bench's sweeps can show that the arithmetic values are right. These are the wrapped sums, the decrement borrow seen at half-carry, and the sign extension of the offset, including the carry out of a low byte that is negative. The add sweep is exhaustive over both operands. The pointer-adjust sweep crosses all 256 offsets with pointers chosen near nibble, byte and word boundaries.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_DEC   = 3'd1,
        ALU_XOR   = 3'd2,
        ALU_CPL   = 3'd3,
        ALU_SPOFS = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/carry_tap.sv
// Adder that also reports the carry into two chosen bit positions.
// Each carry comes from the identity: carry_in[k] = a[k] ^ b[k] ^ sum[k].
module carry_tap #(
    parameter int W        = 8,
    parameter int HALF_BIT = 4,
    parameter int FULL_BIT = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         half_c,
    output logic         full_c
);
    logic [W:0] ax;
    logic [W:0] bx;
    logic [W:0] total;

    assign ax     = {1'b0, a};
    assign bx     = {1'b0, b};
    assign total  = ax + bx;
    assign sum    = total[W-1:0];
    assign half_c = ax[HALF_BIT] ^ bx[HALF_BIT] ^ total[HALF_BIT];
    assign full_c = ax[FULL_BIT] ^ bx[FULL_BIT] ^ total[FULL_BIT];
endmodule

// File: rtl/alu8_byte_path.sv
module alu8_byte_path
    import alu8_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  alu_op_e           op,
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic              keep_z,
    input  logic              keep_c,
    output logic [BYTE_W-1:0] res,
    output alu_flags_t        flg
);
    localparam int HALF = BYTE_W / 2;

    logic [BYTE_W-1:0] add_sum, dec_sum;
    logic              add_h, add_c, dec_h, dec_c;

    carry_tap #(.W(BYTE_W), .HALF_BIT(HALF), .FULL_BIT(BYTE_W)) u_add (
        .a(a), .b(b), .sum(add_sum), .half_c(add_h), .full_c(add_c));

    // Decrement is computed as an add of all ones. A nibble borrow
    // shows up as a missing carry into bit HALF.
    carry_tap #(.W(BYTE_W), .HALF_BIT(HALF), .FULL_BIT(BYTE_W)) u_dec (
        .a(a), .b({BYTE_W{1'b1}}), .sum(dec_sum), .half_c(dec_h), .full_c(dec_c));

    always_comb begin
        res = '0;
        flg = '0;
        unique case (op)
            ALU_ADD: begin
                res   = add_sum;
                flg.z = (add_sum == '0);
                flg.n = 1'b0;
                flg.h = add_h;
                flg.c = add_c;
            end
            ALU_DEC: begin
                res   = dec_sum;
                flg.z = (dec_sum == '0);
                flg.n = 1'b1;
                flg.h = ~dec_h;
                flg.c = keep_c;
            end
            ALU_XOR: begin
                res   = a ^ b;
                flg.z = ((a ^ b) == '0);
            end
            ALU_CPL: begin
                res   = ~a;
                flg.z = keep_z;
                flg.n = 1'b1;
                flg.h = 1'b1;
                flg.c = keep_c;
            end
            default: begin
                res = '0;
                flg = '0;
            end
        endcase
    end

    // R3: the carry out of the all-ones add is the complement of the borrow, so it is set whenever a is non-zero
    always_comb begin
        if (!$isunknown(a))
            a_r3_dec_no_wrap: assert (dec_c == (a != '0));
    end
endmodule

// File: rtl/alu8_wide_path.sv
module alu8_wide_path #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] ptr,
    input  logic [BYTE_W-1:0] ofs,
    output logic [WORD_W-1:0] res,
    output logic              half_c,
    output logic              full_c
);
    localparam int EXT_W = WORD_W - BYTE_W;
    localparam int HALF  = BYTE_W / 2;

    logic [WORD_W-1:0] ofs_ext;

    assign ofs_ext = {{EXT_W{ofs[BYTE_W-1]}}, ofs};

    carry_tap #(.W(WORD_W), .HALF_BIT(HALF), .FULL_BIT(BYTE_W)) u_ptr_add (
        .a(ptr), .b(ofs_ext), .sum(res), .half_c(half_c), .full_c(full_c));

    // R8: with a non-negative offset the adjusted pointer never ends up below the starting pointer unless the word wraps
    always_comb begin
        if (!$isunknown({ptr, ofs}) && !ofs[BYTE_W-1] && (ptr <= ({WORD_W{1'b1}} - ofs_ext)))
            a_r8_forward_move: assert (res >= ptr);
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic [2:0]        op_sel,
    input  logic [BYTE_W-1:0] opnd_a,
    input  logic [BYTE_W-1:0] opnd_b,
    input  logic [WORD_W-1:0] sp_in,
    input  logic [3:0]        flags_in,
    output logic [WORD_W-1:0] result,
    output logic [3:0]        flags_out
);
    localparam int PAD_W = WORD_W - BYTE_W;

    alu_op_e           op;
    alu_flags_t        fin;
    alu_flags_t        byte_flg;
    alu_flags_t        fsel;
    logic [BYTE_W-1:0] byte_res;
    logic [WORD_W-1:0] wide_res;
    logic              wide_h, wide_c;

    assign op  = alu_op_e'(op_sel);
    assign fin = alu_flags_t'(flags_in);

    alu8_byte_path #(.BYTE_W(BYTE_W)) u_byte (
        .op(op), .a(opnd_a), .b(opnd_b), .keep_z(fin.z), .keep_c(fin.c),
        .res(byte_res), .flg(byte_flg));

    alu8_wide_path #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_wide (
        .ptr(sp_in), .ofs(opnd_b), .res(wide_res), .half_c(wide_h), .full_c(wide_c));

    always_comb begin
        result = '0;
        fsel   = fin;
        case (op)
            ALU_ADD, ALU_DEC, ALU_XOR, ALU_CPL: begin
                result = {{PAD_W{1'b0}}, byte_res};
                fsel   = byte_flg;
            end
            ALU_SPOFS: begin
                result = wide_res;
                fsel   = '{z: 1'b0, n: 1'b0, h: wide_h, c: wide_c};
            end
            default: begin
                result = '0;
                fsel   = fin;
            end
        endcase
    end

    assign flags_out = fsel;

    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b, sp_in, flags_in})) begin
            if (op_sel == 3'd0)
                a_r1_add_no_sub: assert (flags_out[2] == 1'b0);
            if (op_sel == 3'd1)
                a_r3_dec_keeps_carry: assert (flags_out[2] && flags_out[0] == flags_in[0]);
            if (op_sel == 3'd2)
                a_r5_xor_clears: assert (flags_out[2:0] == 3'b000);
            if (op_sel == 3'd3)
                a_r7_cpl_keeps: assert (flags_out[3] == flags_in[3] && flags_out[0] == flags_in[0]
                                        && flags_out[2:1] == 2'b11);
            if (op_sel == 3'd4)
                a_r8_spofs_zn: assert (flags_out[3:2] == 2'b00);
            if (op_sel <= 3'd2)
                a_r10_zero_tracks: assert (flags_out[3] == (result[BYTE_W-1:0] == '0));
            if (op_sel >= 3'd5)
                a_r11_passthrough: assert (result == '0 && flags_out == flags_in);
            if (op_sel <= 3'd3)
                a_r12_upper_zero: assert (result[WORD_W-1:BYTE_W] == '0);
        end
    end
endmodule

// File: tb/test_alu8_flags.sv
module test_alu8_flags;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_sel = '0;
    logic [7:0]  opnd_a = '0;
    logic [7:0]  opnd_b = '0;
    logic [15:0] sp_in = '0;
    logic [3:0]  flags_in = '0;
    logic [15:0] result;
    logic [3:0]  flags_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    alu8_flags i_alu8_flags (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .sp_in(sp_in),
        .flags_in(flags_in), .result(result), .flags_out(flags_out));

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst) cycles <= cycles + 1;
        if (cycles >= WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%02h b=%02h sp=%04h fin=%1h: act=%0h exp=%0h",
                     req, op_sel, opnd_a, opnd_b, sp_in, flags_in, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] sp, input logic [3:0] f);
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; sp_in = sp; flags_in = f;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R11: idle code after reset, everything passes through
        drive(3'd7, 8'h00, 8'h00, 16'h0000, 4'b1010);
        check("R11 result", result, 0);
        check("R11 flags", flags_out, 4'b1010);

        // R1 R2 R10 R12: exhaustive add
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                int s;
                s = a + b;
                drive(3'd0, 8'(a), 8'(b), 16'hFFFF, 4'(a + b));
                check("R1", result[7:0], s & 255);
                check("R2", flags_out[1:0],
                      {(((a & 15) + (b & 15)) > 15) ? 1'b1 : 1'b0, (s > 255) ? 1'b1 : 1'b0});
                check("R10", flags_out[3], ((s & 255) == 0) ? 1 : 0);
                if (b == 0) check("R12", result[15:8], 0);
            end
        end

        // R3 R4: decrement with both carry-in values
        for (int a = 0; a < 256; a++) begin
            for (int f = 0; f < 16; f += 5) begin
                drive(3'd1, 8'(a), 8'h5A, 16'h1234, 4'(f));
                check("R3 result", result, (a + 255) & 255);
                check("R3 n/c", {flags_out[2], flags_out[0]}, {1'b1, 1'(f & 1)});
                check("R4", flags_out[1], ((a & 15) == 0) ? 1 : 0);
                check("R10", flags_out[3], (a == 1) ? 1 : 0);
            end
        end

        // R5 R6: exclusive-or over a strided sweep
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 7) begin
                drive(3'd2, 8'(a), 8'(b), 16'h0000, 4'hF);
                check("R5 result", result, a ^ b);
                check("R5 nhc", flags_out[2:0], 0);
            end
            drive(3'd2, 8'(a), 8'(a), 16'h0000, 4'h7);
            check("R6", {flags_out[3], result[7:0]}, 9'h100);
        end

        // R7: invert, all flag-in patterns
        for (int a = 0; a < 256; a++) begin
            for (int f = 0; f < 16; f++) begin
                drive(3'd3, 8'(a), 8'h00, 16'h0000, 4'(f));
                check("R7 result", result, 255 - a);
                check("R7 flags", flags_out, (f & 4'b1001) | 4'b0110);
            end
        end

        // R8 R9: pointer adjust near nibble/byte/word edges
        for (int k = 0; k < 12; k++) begin
            logic [15:0] sp;
            case (k)
                0: sp = 16'h0000;  1: sp = 16'h000F;  2: sp = 16'h00F0;  3: sp = 16'h00FF;
                4: sp = 16'h0100;  5: sp = 16'h7FFF;  6: sp = 16'h8000;  7: sp = 16'hFF80;
                8: sp = 16'hFFF8;  9: sp = 16'hFFFE;  10: sp = 16'h1234; default: sp = 16'hABCD;
            endcase
            for (int e = 0; e < 256; e++) begin
                int off;
                off = (e >= 128) ? e - 256 : e;
                drive(3'd4, 8'h3C, 8'(e), sp, 4'b1100);
                check("R8 result", result, (int'(sp) + off + 65536) & 16'hFFFF);
                check("R8 zn", flags_out[3:2], 0);
                check("R9", flags_out[1:0],
                      {(((sp & 15) + (e & 15)) > 15) ? 1'b1 : 1'b0,
                       (((sp & 255) + e) > 255) ? 1'b1 : 1'b0});
            end
        end

        // R11: every unused code, several flag patterns
        for (int op = 5; op < 8; op++) begin
            for (int f = 0; f < 16; f++) begin
                drive(3'(op), 8'hC3, 8'h81, 16'hBEEF, 4'(f));
                check("R11 result", result, 0);
                check("R11 flags", flags_out, f);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule